// File: doc/BRIEF.md
# Block Register Load Sequencer

This block carries out a multi-register load from memory. A single start strobe supplies a base address, a 16-bit register list and an addressing mode. The sequencer then emits one word address per cycle. Each returning word goes to the register file write port in the cycle after its address was issued, while the next address goes out in that same cycle. A register list with a single register ends with one extra idle cycle.

The block makes four further decisions. It decides whether the base register is updated at the end, and to what value. If a data abort arrives at any point in the burst, it cancels every register write from that transfer onward and puts the base register back to its original value. A load of the program counter, which is always transferred last, raises a one-cycle fetch flush. If the instruction that follows reads the last loaded register, the block requests a one-cycle stall.

Top module: `blkld_seq`

## Requirements
- R1: A start strobe is accepted only while `busy` is low and the list is non-zero. `busy` is high from the next cycle until the end cycle. Strobes arriving while busy, and strobes with an empty list, change nothing.
- R2: In the first busy cycle the block issues a read and writes no register. The read address comes from `amode`, where bit 1 selects increment and bit 0 selects the before variant. With N registers in the list: increment-after reads at base, increment-before at base+4, decrement-after at base-4N+4, and decrement-before at base-4N.
- R3: Registers are transferred in ascending register number. Each later address is the previous one plus 4, so the lowest-numbered register uses the lowest address.
- R4: The word read for address k is written in the following cycle, to the register that address belongs to, with `rf_data` equal to `mem_rdata`. The next address is issued in that same cycle.
- R5: An abort flagged alongside a returning word blocks that write and every later write. The sequence still runs for its normal number of cycles.
- R6: In the end cycle without an abort, `base_we` pulses when writeback is enabled and the base register is not in the list. The value is base+4N for increment modes and base-4N for decrement modes. If the base register is in the list, the loaded value stands.
- R7: In the end cycle after any abort, `base_we` pulses with the original base value.
- R8: When register 15 is in the list it is written last, and `flush` is high for exactly that write cycle. After an abort, `flush` stays low.
- R9: For a list of two or more registers with no abort, `stall` is high for the one cycle after the end cycle if either next-instruction operand (with its valid bit set) names the last loaded register.
- R10: A one-register list writes in its second busy cycle and ends with an idle third cycle. It never raises `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe |
| base_val | input | 32 | Base register value |
| base_idx | input | 4 | Number of the base register |
| reg_list | input | 16 | Register list, bit i selects register i |
| amode | input | 2 | Addressing mode (bit 1 increment, bit 0 before) |
| wb_en | input | 1 | Base writeback enable |
| nxt_ra | input | 4 | Next instruction operand A register |
| nxt_ra_vld | input | 1 | Operand A is read |
| nxt_rb | input | 4 | Next instruction operand B / store data register |
| nxt_rb_vld | input | 1 | Operand B is read |
| mem_rdata | input | 32 | Read data for the previous cycle's address |
| mem_abort | input | 1 | Abort flag for the returning word |
| busy | output | 1 | Sequence in progress |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 32 | Word address |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | 4 | Register written |
| rf_data | output | 32 | Register write data |
| base_we | output | 1 | Base register write enable |
| base_data | output | 32 | Base register write value |
| flush | output | 1 | Fetch pipeline flush |
| stall | output | 1 | Load-use stall request |

## Verification
The checker assumes that `mem_abort` is raised only in a cycle that returns a word, never in the first busy cycle or while idle. Under that assumption its sticky abort tracker lines up with the design. The bench drives the abort for exactly one chosen data cycle, or not at all, and otherwise holds it low. It holds the next-instruction operands constant for each whole sequence, and it keeps base values large and word-aligned so that decrement modes never wrap.

// File: rtl/blkld_pkg.sv
// Package: shared phase type and mode bit positions for the block load sequencer.
// Assumes word-granular addressing with 4-byte words.
package blkld_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FIRST = 2'd1,
        PH_XFER  = 2'd2,
        PH_TAIL  = 2'd3
    } phase_t;

    localparam int unsigned MODE_INC_BIT    = 1;
    localparam int unsigned MODE_BEFORE_BIT = 0;
    localparam int unsigned WORD_BYTES      = 4;
endpackage

// File: rtl/blkld_plan.sv
// Module: blkld_plan
// Counts the registers in a list and derives the first transfer address and
// the written-back base. Purely combinational; the caller samples the results
// at the start strobe. Assumes the base is word-aligned.
module blkld_plan #(
    parameter int unsigned NREG = 16,
    parameter int unsigned AW   = 32,
    localparam int unsigned CW  = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0] list,
    input  logic [AW-1:0]   base,
    input  logic [1:0]      mode,
    output logic [CW-1:0]   cnt,
    output logic [AW-1:0]   first_addr,
    output logic [AW-1:0]   next_base
);
    import blkld_pkg::*;

    logic [AW-1:0] span;
    logic [AW-1:0] word;

    // Population count of the register list.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < int'(NREG); i++) begin
            cnt = cnt + CW'(list[i]);
        end
    end

    // Start address and final base from the mode bits.
    always_comb begin
        word = AW'(WORD_BYTES);
        span = AW'(cnt) * word;
        if (mode[MODE_INC_BIT]) begin
            first_addr = mode[MODE_BEFORE_BIT] ? base + word : base;
            next_base  = base + span;
        end else begin
            first_addr = mode[MODE_BEFORE_BIT] ? base - span : base - span + word;
            next_base  = base - span;
        end
    end
endmodule

// File: rtl/blkld_pick.sv
// Module: blkld_pick
// Priority picker: returns the index of the lowest set bit of a mask, and
// whether any bit is set. Combinational.
module blkld_pick #(
    parameter int unsigned NREG = 16,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic [NREG-1:0] mask,
    output logic [IW-1:0]   idx,
    output logic            any
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        any = |mask;
        for (int i = int'(NREG) - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/blkld_seq.sv
// Module: blkld_seq (top)
// Multi-cycle block register load. The first busy cycle issues only the first
// address. Each later cycle writes the word for the previous address and issues
// the next one. The last cycle decides the base update. Aborts cancel writes
// from the aborted word onward and restore the base. A one-register list ends
// with an idle cycle. Assumes memory returns data and abort one cycle after
// the address, and that mem_abort is raised only in data cycles.
module blkld_seq #(
    parameter int unsigned NREG   = 16,
    parameter int unsigned AW     = 32,
    parameter int unsigned DW     = 32,
    parameter int unsigned PC_IDX = 15,
    localparam int unsigned IW    = $clog2(NREG),
    localparam int unsigned CW    = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   base_val,
    input  logic [IW-1:0]   base_idx,
    input  logic [NREG-1:0] reg_list,
    input  logic [1:0]      amode,
    input  logic            wb_en,
    input  logic [IW-1:0]   nxt_ra,
    input  logic            nxt_ra_vld,
    input  logic [IW-1:0]   nxt_rb,
    input  logic            nxt_rb_vld,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_abort,
    output logic            busy,
    output logic            mem_rd,
    output logic [AW-1:0]   mem_addr,
    output logic            rf_we,
    output logic [IW-1:0]   rf_idx,
    output logic [DW-1:0]   rf_data,
    output logic            base_we,
    output logic [AW-1:0]   base_data,
    output logic            flush,
    output logic            stall
);
    import blkld_pkg::*;

    phase_t          phase_q;
    logic [NREG-1:0] rem_q;
    logic [IW-1:0]   cur_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   orig_q;
    logic [AW-1:0]   newb_q;
    logic            wb_q;
    logic            single_q;
    logic            binl_q;
    logic            ab_q;
    logic            stall_q;

    logic [CW-1:0]   pl_cnt;
    logic [AW-1:0]   pl_first;
    logic [AW-1:0]   pl_next;
    logic [IW-1:0]   pk_idx;
    logic            pk_any;

    logic            accept;
    logic            last_xfer;
    logic            end_c;
    logic            ab_now;
    logic            hit;

    blkld_plan #(.NREG(NREG), .AW(AW)) u_plan (
        .list       (reg_list),
        .base       (base_val),
        .mode       (amode),
        .cnt        (pl_cnt),
        .first_addr (pl_first),
        .next_base  (pl_next)
    );

    blkld_pick #(.NREG(NREG)) u_pick (
        .mask (rem_q),
        .idx  (pk_idx),
        .any  (pk_any)
    );

    // Per-cycle decode of the phase into port activity.
    always_comb begin
        accept    = (phase_q == PH_IDLE) && start && (|reg_list);
        busy      = (phase_q != PH_IDLE);
        mem_rd    = (phase_q == PH_FIRST) || ((phase_q == PH_XFER) && pk_any);
        mem_addr  = addr_q;
        rf_we     = (phase_q == PH_XFER) && !ab_q && !mem_abort;
        rf_idx    = cur_q;
        rf_data   = mem_rdata;
        last_xfer = (phase_q == PH_XFER) && !pk_any;
        end_c     = (last_xfer && !single_q) || (phase_q == PH_TAIL);
        ab_now    = ab_q || ((phase_q == PH_XFER) && mem_abort);
        base_we   = end_c && (ab_now || (wb_q && !binl_q));
        base_data = ab_now ? orig_q : newb_q;
        flush     = rf_we && (cur_q == IW'(PC_IDX));
        hit       = (nxt_ra_vld && (nxt_ra == cur_q)) || (nxt_rb_vld && (nxt_rb == cur_q));
        stall     = stall_q;
    end

    // Phase sequencing, address stepping and capture of the instruction fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            rem_q    <= '0;
            cur_q    <= '0;
            addr_q   <= '0;
            orig_q   <= '0;
            newb_q   <= '0;
            wb_q     <= 1'b0;
            single_q <= 1'b0;
            binl_q   <= 1'b0;
            ab_q     <= 1'b0;
            stall_q  <= 1'b0;
        end else begin
            stall_q <= last_xfer && !single_q && rf_we && hit;
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        addr_q   <= pl_first;
                        rem_q    <= reg_list;
                        orig_q   <= base_val;
                        newb_q   <= pl_next;
                        wb_q     <= wb_en;
                        single_q <= (pl_cnt == CW'(1));
                        binl_q   <= reg_list[base_idx];
                        ab_q     <= 1'b0;
                        phase_q  <= PH_FIRST;
                    end
                end
                PH_FIRST: begin
                    cur_q   <= pk_idx;
                    rem_q   <= rem_q & (rem_q - NREG'(1));
                    addr_q  <= addr_q + AW'(WORD_BYTES);
                    phase_q <= PH_XFER;
                end
                PH_XFER: begin
                    ab_q <= ab_now;
                    if (pk_any) begin
                        cur_q  <= pk_idx;
                        rem_q  <= rem_q & (rem_q - NREG'(1));
                        addr_q <= addr_q + AW'(WORD_BYTES);
                    end else begin
                        phase_q <= single_q ? PH_TAIL : PH_IDLE;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/blkld_seq_chk.sv
// Module: blkld_seq_chk
// Temporal checks on the sequencer ports, bound into every blkld_seq.
// Assumes mem_abort is raised only in data-return cycles.
module blkld_seq_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          mem_abort,
    input logic          rf_we,
    input logic [IW-1:0] rf_idx,
    input logic          flush,
    input logic          stall
);
    logic          ab_seen;
    logic          we_seen;
    logic [IW-1:0] last_w;

    // Track aborts and the last written register within one sequence.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            ab_seen <= 1'b0;
            we_seen <= 1'b0;
            last_w  <= '0;
        end else begin
            if (mem_abort) ab_seen <= 1'b1;
            if (rf_we) begin
                we_seen <= 1'b1;
                last_w  <= rf_idx;
            end
        end
    end

    a_r2_first_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_rd && !rf_we));

    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + AW'(4)));

    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && we_seen) |-> (rf_idx > last_w));

    a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(mem_rd));

    a_r5_no_write_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (!ab_seen && !mem_abort));

    a_r8_flush_on_pc: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (rf_we && (rf_idx == IW'(15))));

    a_r8_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    a_r9_stall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!busy && !rf_we));

    a_r9_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
endmodule

bind blkld_seq blkld_seq_chk #(.AW(AW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_abort (mem_abort),
    .rf_we     (rf_we),
    .rf_idx    (rf_idx),
    .flush     (flush),
    .stall     (stall)
);

// File: tb/blkld_seq_tb.sv
`timescale 1ns/1ps
module blkld_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_val = '0;
    logic [3:0]  base_idx = '0;
    logic [15:0] reg_list = '0;
    logic [1:0]  amode = '0;
    logic        wb_en = 1'b0;
    logic [3:0]  nxt_ra = '0;
    logic        nxt_ra_vld = 1'b0;
    logic [3:0]  nxt_rb = '0;
    logic        nxt_rb_vld = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_abort = 1'b0;
    logic        busy, mem_rd, rf_we, base_we, flush, stall;
    logic [31:0] mem_addr, rf_data, base_data;
    logic [3:0]  rf_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    blkld_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_val(base_val),
        .base_idx(base_idx), .reg_list(reg_list), .amode(amode), .wb_en(wb_en),
        .nxt_ra(nxt_ra), .nxt_ra_vld(nxt_ra_vld), .nxt_rb(nxt_rb),
        .nxt_rb_vld(nxt_rb_vld), .mem_rdata(mem_rdata), .mem_abort(mem_abort),
        .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr), .rf_we(rf_we),
        .rf_idx(rf_idx), .rf_data(rf_data), .base_we(base_we),
        .base_data(base_data), .flush(flush), .stall(stall)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int popc(input logic [15:0] l);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(l[i]);
        return c;
    endfunction

    function automatic int nth_reg(input logic [15:0] l, input int j);
        int c = 0;
        for (int i = 0; i < 16; i++) begin
            if (l[i]) begin
                if (c == j) return i;
                c++;
            end
        end
        return -1;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'd2654435761) ^ 32'h5A5A_C3C3;
    endfunction

    // One complete sequence, checked cycle by cycle at the ports.
    task automatic run_op(input logic [15:0] l, input logic [1:0] md, input bit wb,
                          input logic [3:0] rn, input int abp, input int kind,
                          input bit hammer, input logic [31:0] b);
        int n = popc(l);
        int e = (n > 1) ? n + 1 : n + 2;
        bit abn = (abp < n);
        int lastr = nth_reg(l, n - 1);
        logic [31:0] sa, nb;
        if (md[1]) begin
            sa = md[0] ? b + 4 : b;
            nb = b + 32'(4 * n);
        end else begin
            sa = md[0] ? b - 32'(4 * n) : b - 32'(4 * n) + 4;
            nb = b - 32'(4 * n);
        end
        @(negedge clk);
        start = 1'b1; reg_list = l; amode = md; wb_en = wb; base_idx = rn; base_val = b;
        nxt_ra = (kind == 0) ? 4'(lastr) : 4'(lastr) ^ 4'd1;
        nxt_ra_vld = 1'b1;
        nxt_rb = 4'(lastr);
        nxt_rb_vld = (kind == 1);
        for (int cyc = 1; cyc <= e + 1; cyc++) begin
            int j = cyc - 2;
            @(negedge clk);
            start = hammer && (cyc <= e);
            if (hammer) begin reg_list = 16'hFFFF; base_val = 32'h1234_0000; end
            if (j >= 0 && j < n) begin
                mem_rdata = mem_word(sa + 32'(4 * j));
                mem_abort = (j == abp);
            end else begin
                mem_rdata = 32'h0;
                mem_abort = 1'b0;
            end
            #1;
            check(busy == (cyc <= e), "R1 busy window", 32'(busy), 32'(cyc <= e));
            check(mem_rd == (cyc <= n), "R3 read request", 32'(mem_rd), 32'(cyc <= n));
            if (cyc == 1)
                check(mem_addr == sa, "R2 first address", mem_addr, sa);
            else if (cyc <= n)
                check(mem_addr == sa + 32'(4 * (cyc - 1)), "R3 address step", mem_addr, sa + 32'(4 * (cyc - 1)));
            begin
                bit ew = (j >= 0) && (j < n) && (j < abp);
                check(rf_we == ew, abn ? "R5 write cut by abort" : (cyc == 1 ? "R2 no first write" : "R4 write enable"),
                      32'(rf_we), 32'(ew));
                if (ew) begin
                    check(rf_idx == 4'(nth_reg(l, j)), "R3 register order", 32'(rf_idx), 32'(nth_reg(l, j)));
                    check(rf_data == mem_word(sa + 32'(4 * j)), "R4 write data", rf_data, mem_word(sa + 32'(4 * j)));
                end
            end
            begin
                bit ef = (cyc == n + 1) && l[15] && !abn;
                check(flush == ef, "R8 flush", 32'(flush), 32'(ef));
            end
            begin
                bit eb = (cyc == e) && (abn || (wb && !l[rn]));
                check(base_we == eb, abn ? "R7 base restore enable" : "R6 base write enable", 32'(base_we), 32'(eb));
                if (eb && abn) check(base_data == b, "R7 base restore value", base_data, b);
                if (eb && !abn) check(base_data == nb, "R6 new base value", base_data, nb);
            end
            begin
                bit es = (cyc == e + 1) && (n > 1) && !abn && (kind != 2);
                check(stall == es, (n == 1) ? "R10 no stall single" : "R9 load-use stall", 32'(stall), 32'(es));
            end
        end
        start = 1'b0;
    endtask

    localparam logic [15:0] MULTI [8] = '{16'hFFFF, 16'h8001, 16'h0006, 16'h80F0,
                                          16'h1234, 16'hA55A, 16'h000F, 16'hC000};

    initial begin
        int opn = 0;
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !mem_rd && !rf_we && !base_we && !flush && !stall, "R1 reset state",
              {26'd0, busy, mem_rd, rf_we, base_we, flush, stall}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // Empty list start is ignored.
        @(negedge clk);
        start = 1'b1; reg_list = 16'h0000;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(!busy && !mem_rd, "R1 empty list ignored", 32'(busy), 32'd0);
        for (int li = 0; li < 24; li++) begin
            logic [15:0] l = (li < 16) ? (16'd1 << li) : MULTI[li - 16];
            int n = popc(l);
            for (int md = 0; md < 4; md++) begin
                for (int wb = 0; wb < 2; wb++) begin
                    for (int ap = 0; ap < 4; ap++) begin
                        int abp = (ap == 0) ? n : (ap == 1) ? 0 : (ap == 2) ? n - 1 : n / 2;
                        run_op(l, 2'(md), wb[0], 4'(opn * 7), abp, opn % 3, (opn % 5) == 0,
                               32'h0010_0000 + 32'(opn * 64));
                        opn++;
                    end
                end
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule